// File: doc/BRIEF.md
# Pattern-Driven Memory Write Generator

This block fills a region of memory by issuing a stream of write requests, each carrying a target address and a data word. Two small tables hold the pattern: one holds target addresses, the other holds data words. Both tables are read at the same pattern index. Software loads the tables through a simple write port. It then sets the shaping controls and the number of writes wanted, and pulses `start` while `ready` is high.

The pattern index is built from a step counter. A divider decides how many writes use the same index. A pattern mask, or a modulo limit, makes the index wrap. The address read from the table is then confined to a window, either by ANDing it with a memory mask or by reducing it modulo (mask + 1). The data word is bit-inverted for selected rows, where the row is the address with its column bits dropped.

All shaping controls are captured when `start` is accepted. Changing them during a run has no effect on that run. Writes complete only on a valid/ready handshake, so the downstream sink may stall for any number of cycles.

Top module: `pattern_writer`

## Requirements
- R1: After reset `ready` is 1, `req_valid` is 0, `done_count` is 0 and `last_addr` is 0.
- R2: In mask mode (`use_modulo`=0), write k uses table entry i = (k / (`step_div`+1)) & `pat_mask`. Its address and data both come from entry i of the two tables, before the address and data rules below.
- R3: In mask mode the emitted address is the table address ANDed with `mem_mask`.
- R4: In modulo mode (`use_modulo`=1) the entry is i = (k / (`step_div`+1)) mod (`pat_mask`+1). The emitted address is the table address mod (`mem_mask`+1).
- R5: `step_div` holds the divisor minus one. The pattern index advances once every `step_div`+1 completed writes.
- R6: The emitted data is the bitwise inverse of the table data exactly when ((address >> COL_BITS) & `inv_div_mask`) == `inv_sel_mask`. Otherwise it is the table data unchanged.
- R7: A write completes only in a cycle with `req_valid`=1 and `req_ready`=1. While `req_valid`=1 and `req_ready`=0, `req_valid`, `req_addr` and `req_data` hold their values into the next cycle.
- R8: After a start with a nonzero count, `ready` reads 0 from the next cycle until the last write completes. `ready` reads 1 in the cycle after `done_count` reaches the latched count.
- R9: A `start` pulse while `ready` is 0 is ignored. The running count, the configuration and `done_count` are not affected.
- R10: A start with `xfer_count`=0 issues no request, keeps `ready` at 1 and sets `done_count` to 0.
- R11: `last_addr` holds the address of the most recently completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern table write enable |
| pat_waddr | input | PAT_AW | Pattern table entry to write |
| pat_wtarget | input | ADDR_W | Address value stored in the entry |
| pat_wdata | input | DATA_W | Data value stored in the entry |
| start | input | 1 | Start pulse, accepted only while ready |
| xfer_count | input | CNT_W | Number of writes for the run |
| use_modulo | input | 1 | 1 selects modulo wrapping, 0 selects masking |
| mem_mask | input | ADDR_W | Address window mask (modulo mode: limit minus one) |
| pat_mask | input | PAT_AW | Pattern index mask (modulo mode: limit minus one) |
| step_div | input | CNT_W | Writes per pattern index, minus one |
| inv_div_mask | input | ADDR_W | Row bits compared for inversion |
| inv_sel_mask | input | ADDR_W | Row value that selects inversion |
| ready | output | 1 | High when no run is in progress |
| done_count | output | CNT_W | Writes completed in the current or last run |
| last_addr | output | ADDR_W | Address of the last completed write |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Sink accepts the request |
| req_addr | output | ADDR_W | Write request address |
| req_data | output | DATA_W | Write request data |

## Verification
The hardest case to reach is a `start` pulse that arrives mid-run. It must carry a different count and different shaping controls, and it must arrive while the sink is stalling. The run that follows must match the first configuration exactly. The bench first waits for a request to appear under a randomly stalling sink. It then pulses `start` with new values and changes every control input, and the scoreboard checks that each write still follows the original expected list. Divider and modulo wrapping are also checked against a model. Table addresses are chosen larger than the modulus, so a masking result and a modulo result differ.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_SEND  = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_pattern_ram.sv
module pw_pattern_ram #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pw_index_gen.sv
module pw_index_gen #(
  parameter int PAT_AW = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic              use_modulo,
  input  logic [PAT_AW-1:0] pat_mask,
  input  logic [CNT_W-1:0]  step_div,
  output logic [PAT_AW-1:0] idx
);
  logic [CNT_W-1:0]  div_cnt;
  logic [PAT_AW-1:0] seq;
  logic [PAT_AW-1:0] mod_idx;
  logic              advance;

  assign advance = step && (div_cnt == step_div);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_cnt <= '0;
      seq     <= '0;
      mod_idx <= '0;
    end else if (step) begin
      div_cnt <= advance ? '0 : div_cnt + 1'b1;
      if (advance) begin
        seq     <= seq + 1'b1;
        mod_idx <= (mod_idx >= pat_mask) ? '0 : mod_idx + 1'b1;
      end
    end
  end

  assign idx = use_modulo ? mod_idx : (seq & pat_mask);

  AST_MOD_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (use_modulo && !clear && !$past(clear)) |-> (mod_idx <= pat_mask)) else $error("mod idx range"); // R4
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |-> (div_cnt <= step_div)) else $error("div range"); // R5
endmodule

// File: rtl/pw_target_map.sv
module pw_target_map #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int COL_BITS = 4
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              use_modulo,
  input  logic [ADDR_W-1:0] mem_mask,
  input  logic [ADDR_W-1:0] inv_div_mask,
  input  logic [ADDR_W-1:0] inv_sel_mask,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic [ADDR_W:0]   modulus;
  logic [ADDR_W:0]   reduced;
  logic [ADDR_W-1:0] row;
  logic              invert;

  always_comb begin
    modulus  = {1'b0, mem_mask} + 1'b1;
    reduced  = {1'b0, raw_addr} % modulus;
    out_addr = use_modulo ? reduced[ADDR_W-1:0] : (raw_addr & mem_mask);
    row      = out_addr >> COL_BITS;
    invert   = ((row & inv_div_mask) == inv_sel_mask);
    out_data = invert ? ~raw_data : raw_data;
  end
endmodule

// File: rtl/pattern_writer.sv
module pattern_writer #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int PAT_AW   = 5,
  parameter int CNT_W    = 16,
  parameter int COL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pat_we,
  input  logic [PAT_AW-1:0] pat_waddr,
  input  logic [ADDR_W-1:0] pat_wtarget,
  input  logic [DATA_W-1:0] pat_wdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              use_modulo,
  input  logic [ADDR_W-1:0] mem_mask,
  input  logic [PAT_AW-1:0] pat_mask,
  input  logic [CNT_W-1:0]  step_div,
  input  logic [ADDR_W-1:0] inv_div_mask,
  input  logic [ADDR_W-1:0] inv_sel_mask,
  output logic              ready,
  output logic [CNT_W-1:0]  done_count,
  output logic [ADDR_W-1:0] last_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  import pw_pkg::*;

  pw_state_e         state;
  logic [CNT_W-1:0]  c_count;
  logic              c_mod;
  logic [ADDR_W-1:0] c_mmask;
  logic [PAT_AW-1:0] c_pmask;
  logic [CNT_W-1:0]  c_div;
  logic [ADDR_W-1:0] c_idm;
  logic [ADDR_W-1:0] c_ism;

  logic              accept;
  logic              handshake;
  logic [PAT_AW-1:0] idx;
  logic [ADDR_W-1:0] tab_addr;
  logic [DATA_W-1:0] tab_data;
  logic [ADDR_W-1:0] map_addr;
  logic [DATA_W-1:0] map_data;
  logic [CNT_W-1:0]  done_next;

  assign accept    = start && (state == ST_IDLE);
  assign handshake = req_valid && req_ready;
  assign done_next = done_count + 1'b1;
  assign ready     = (state == ST_IDLE);

  pw_pattern_ram #(.AW(PAT_AW), .W(ADDR_W)) u_addr_tab (
    .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wtarget),
    .raddr(idx), .rdata(tab_addr));

  pw_pattern_ram #(.AW(PAT_AW), .W(DATA_W)) u_data_tab (
    .clk(clk), .we(pat_we), .waddr(pat_waddr), .wdata(pat_wdata),
    .raddr(idx), .rdata(tab_data));

  pw_index_gen #(.PAT_AW(PAT_AW), .CNT_W(CNT_W)) u_index (
    .clk(clk), .rst(rst), .clear(accept), .step(handshake),
    .use_modulo(c_mod), .pat_mask(c_pmask), .step_div(c_div), .idx(idx));

  pw_target_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_map (
    .raw_addr(tab_addr), .raw_data(tab_data), .use_modulo(c_mod),
    .mem_mask(c_mmask), .inv_div_mask(c_idm), .inv_sel_mask(c_ism),
    .out_addr(map_addr), .out_data(map_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      c_count    <= '0;
      c_mod      <= 1'b0;
      c_mmask    <= '0;
      c_pmask    <= '0;
      c_div      <= '0;
      c_idm      <= '0;
      c_ism      <= '0;
      done_count <= '0;
      last_addr  <= '0;
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            c_count    <= xfer_count;
            c_mod      <= use_modulo;
            c_mmask    <= mem_mask;
            c_pmask    <= pat_mask;
            c_div      <= step_div;
            c_idm      <= inv_div_mask;
            c_ism      <= inv_sel_mask;
            done_count <= '0;
            if (xfer_count != '0) state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          req_addr  <= map_addr;
          req_data  <= map_data;
          req_valid <= 1'b1;
          state     <= ST_SEND;
        end
        ST_SEND: begin
          if (req_ready) begin
            req_valid  <= 1'b0;
            done_count <= done_next;
            last_addr  <= req_addr;
            state      <= (done_next == c_count) ? ST_IDLE : ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)))
    else $error("stall hold"); // R7
  AST_BUSY_WHEN_VALID: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !ready) else $error("busy when valid"); // R8
  AST_DONE_ONLY_ON_HS: assert property (@(posedge clk) disable iff (rst)
    (!accept && !handshake) |=> $stable(done_count)) else $error("done step"); // R7
  AST_DONE_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (done_count < c_count)) else $error("done bound"); // R8
  AST_MASK_CONFINE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !c_mod) |-> ((req_addr & ~c_mmask) == '0)) else $error("mask confine"); // R3
  AST_MOD_CONFINE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && c_mod) |-> (req_addr <= c_mmask)) else $error("mod confine"); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && !ready) |=> $stable(c_count)) else $error("start ignored"); // R9
endmodule

// File: tb/tb_pattern_writer.sv
`timescale 1ns/1ps
module tb_pattern_writer;
  localparam int ADDR_W = 16, DATA_W = 32, PAT_AW = 5, CNT_W = 16, COL_BITS = 4;
  localparam int DEPTH = 1 << PAT_AW;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic              pat_we = 0;
  logic [PAT_AW-1:0] pat_waddr = '0;
  logic [ADDR_W-1:0] pat_wtarget = '0;
  logic [DATA_W-1:0] pat_wdata = '0;
  logic              start = 0;
  logic [CNT_W-1:0]  xfer_count = '0;
  logic              use_modulo = 0;
  logic [ADDR_W-1:0] mem_mask = '1;
  logic [PAT_AW-1:0] pat_mask = '0;
  logic [CNT_W-1:0]  step_div = '0;
  logic [ADDR_W-1:0] inv_div_mask = '0;
  logic [ADDR_W-1:0] inv_sel_mask = 16'h0001;
  logic              ready, req_valid, req_ready;
  logic [CNT_W-1:0]  done_count;
  logic [ADDR_W-1:0] last_addr, req_addr;
  logic [DATA_W-1:0] req_data;

  pattern_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_AW(PAT_AW),
                   .CNT_W(CNT_W), .COL_BITS(COL_BITS)) dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit stall_en = 0;
  string cur_req = "R2";
  logic [ADDR_W-1:0] ta [DEPTH];
  logic [DATA_W-1:0] td [DEPTH];
  logic [ADDR_W-1:0] q_addr [$];
  logic [DATA_W-1:0] q_data [$];
  logic [ADDR_W-1:0] exp_last = '0;

  assign req_ready = rdy;
  logic rdy = 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    rdy = stall_en ? (($urandom % 3) != 0) : 1'b1;
    #0.5;
    if (!rst && req_valid && rdy) begin
      if (q_addr.size() == 0) begin
        check(0, cur_req, "unexpected request", req_addr, 0);
      end else begin
        logic [ADDR_W-1:0] ea;
        logic [DATA_W-1:0] ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        check(req_addr == ea, cur_req, "req_addr", req_addr, ea);
        check(req_data == ed, cur_req, "req_data", req_data, ed);
      end
    end
  end

  function automatic void model(input int k, input bit m, input logic [ADDR_W-1:0] mm,
                                input logic [PAT_AW-1:0] pm, input logic [CNT_W-1:0] dv,
                                input logic [ADDR_W-1:0] idm, input logic [ADDR_W-1:0] ism,
                                output logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    int seq, idx;
    logic [ADDR_W-1:0] row;
    seq = k / (int'(dv) + 1);
    idx = m ? (seq % (int'(pm) + 1)) : (seq & int'(pm));
    a   = m ? ADDR_W'(int'(ta[idx]) % (int'(mm) + 1)) : (ta[idx] & mm);
    row = a >> COL_BITS;
    d   = ((row & idm) == ism) ? ~td[idx] : td[idx];
  endfunction

  task automatic launch(input int cnt, input bit m, input logic [ADDR_W-1:0] mm,
                        input logic [PAT_AW-1:0] pm, input logic [CNT_W-1:0] dv,
                        input logic [ADDR_W-1:0] idm, input logic [ADDR_W-1:0] ism);
    for (int k = 0; k < cnt; k++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      model(k, m, mm, pm, dv, idm, ism, a, d);
      q_addr.push_back(a);
      q_data.push_back(d);
      exp_last = a;
    end
    @(negedge clk);
    xfer_count = CNT_W'(cnt); use_modulo = m; mem_mask = mm; pat_mask = pm;
    step_div = dv; inv_div_mask = idm; inv_sel_mask = ism; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_run(input int cnt, input string req);
    int guard = 0;
    check(ready == 1'b0, "R8", "ready low during run", ready, 0);
    while (ready !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    #1;
    check(ready == 1'b1, "R8", "ready back", ready, 1);
    check(done_count == CNT_W'(cnt), "R8", "done_count", done_count, cnt);
    check(last_addr == exp_last, "R11", "last_addr", last_addr, exp_last);
    check(q_addr.size() == 0, req, "items left", q_addr.size(), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ta[i] = ADDR_W'(16'h0a30 + i * 16'h0153);
      td[i] = 32'hc3000000 ^ (i * 32'h01010101) ^ (i << 20);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(ready == 1 && req_valid == 0 && done_count == 0 && last_addr == 0,
          "R1", "reset state", {ready, req_valid, done_count}, {1'b1, 1'b0, 16'h0});
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      pat_we = 1; pat_waddr = PAT_AW'(i); pat_wtarget = ta[i]; pat_wdata = td[i];
    end
    @(negedge clk);
    pat_we = 0;

    cur_req = "R2"; stall_en = 0;
    launch(6, 0, 16'hffff, 5'd1, 0, 16'h0, 16'h1);
    finish_run(6, "R2");

    cur_req = "R3"; stall_en = 1;
    launch(10, 0, 16'h00ff, 5'd7, 0, 16'h0, 16'h1);
    finish_run(10, "R3");

    cur_req = "R4";
    launch(12, 1, 16'd999, 5'd4, 0, 16'h0, 16'h1);
    finish_run(12, "R4");

    cur_req = "R5";
    launch(12, 0, 16'hffff, 5'd3, 16'd2, 16'h0, 16'h1);
    finish_run(12, "R5");

    cur_req = "R6"; stall_en = 0;
    launch(16, 0, 16'hffff, 5'd15, 0, 16'h1, 16'h1);
    finish_run(16, "R6");

    // R9: start during run with different settings must be ignored
    cur_req = "R9"; stall_en = 1;
    launch(8, 1, 16'h07ff, 5'd5, 16'd1, 16'h2, 16'h2);
    while (req_valid !== 1'b1) @(negedge clk);
    xfer_count = 3; use_modulo = 0; mem_mask = 16'h000f; pat_mask = 0;
    step_div = 7; inv_div_mask = 0; inv_sel_mask = 0; start = 1;
    @(negedge clk);
    start = 0;
    finish_run(8, "R9");

    // R10: zero count
    cur_req = "R10"; stall_en = 0;
    @(negedge clk);
    xfer_count = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) begin
      @(negedge clk);
      #1;
      check(ready == 1 && req_valid == 0, "R10", "zero count idle",
            {ready, req_valid}, 2'b10);
    end
    check(done_count == 0, "R10", "zero count done", done_count, 0);
    check(last_addr == exp_last, "R11", "last_addr kept", last_addr, exp_last);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule